// File: doc/BRIEF.md
# Random Word Post-Processor

This block turns a stream of single noise bits into 32-bit random words. Each incoming bit can go straight through, or through one or both of two conditioning stages. The first is a bit-serial Galois LFSR that the raw bit is mixed into. The second is a von Neumann pair corrector. Processed bits are packed into a word. When the word is full it is held for a reader, and a status flag shows that it is ready.

A plain control word chooses the conditioning path, switches the noise input on or off, and selects a deterministic test source. The test source is a fixed-seed internal generator, so a run from reset always yields the same words. Raw bits enter on a valid/ready stream. `raw_rdy` is high only when the block will take a bit: noise is enabled, test mode is off, and no finished word is waiting. A bit is consumed on each rising clock edge where `raw_vld` and `raw_rdy` are both high. A producer may hold `raw_vld` high for as long as it likes; while `raw_rdy` is low, nothing is taken. Reading the data register by pulsing `rd_en` takes the pending word and restarts collection.

Top module: `rng_post_unit`

## Requirements
- R1: The control word field meanings are as follows. Bits 9:8 select post-processing (0 none, 1 LFSR, 2 whitener, 3 LFSR then whitener). Bit 10 enables noise. Bit 11 selects test mode. All other control bits have no effect on the output words.
- R2: While bit 10 is low, `raw_rdy` is low, no bits are gathered, and status bit 0 never sets.
- R3: Processed bits are shifted into the word from the least significant end. After 32 bits, the first gathered bit sits in bit 31 and the last in bit 0. With select 0, each accepted raw bit is a processed bit unchanged.
- R4: With select 1, each accepted bit b updates a 32-bit state s, which reset sets to 32'h00000001. The stage computes f = s[0] ^ b, emits f as the processed bit, and sets s to (s >> 1) ^ (f ? 32'h80200003 : 0).
- R5: With select 2, input bits are paired in arrival order. The pair (0,1) emits 0, the pair (1,0) emits 1, and the pairs (0,0) and (1,1) emit nothing.
- R6: With select 3, the output of the R4 stage feeds the R5 stage.
- R7: With bits 10 and 11 both high, the raw port is ignored and `raw_rdy` is low. One bit per cycle is taken from an internal state t, which reset sets to 32'hACE12025. Each cycle the bit emitted is t[0], and t becomes (t >> 1) ^ (t[0] ? 32'h80200003 : 0). Runs from reset therefore give identical words.
- R8: Status bit 0 is high while a finished word is held. Status bits 31:1 are always 0. `rd_data` presents all 32 bits of the held word.
- R9: A cycle with `rd_en` high while status bit 0 is high clears that bit on the next edge. `rd_en` while the bit is low changes nothing.
- R10: While a word is held, no bits are accepted and the held word does not change. After a read, a new word needs 32 newly processed bits.
- R11: A raw bit is consumed exactly on an edge where `raw_vld` and `raw_rdy` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_word | input | 16 | Control: [9:8] path select, [10] noise enable, [11] test mode |
| raw_vld | input | 1 | Raw noise bit valid |
| raw_bit | input | 1 | Raw noise bit |
| raw_rdy | output | 1 | Block will take a raw bit this cycle |
| rd_en | input | 1 | Data register read strobe |
| stat_word | output | 32 | Status; bit 0 means a word is ready |
| rd_data | output | 32 | Held random word |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 32-bit LFSR with taps 32'h80200003, and the seeds stated above. These values make the expected words computable from the requirement formulas alone. With them, every path select, the pairing state carried across words, and the repeatability of test mode from reset can all be compared bit for bit. The 32-bit word also keeps each fill short enough to exercise refill after a read, bits offered while a word is held, and reads of an empty register many times over in one run.

// File: rtl/rng_post_pkg.sv
package rng_post_pkg;
  typedef enum logic [1:0] {
    PP_NONE  = 2'd0,
    PP_LFSR  = 2'd1,
    PP_WHITE = 2'd2,
    PP_BOTH  = 2'd3
  } pp_sel_e;

  localparam int CTRL_W     = 16;
  localparam int CF_SEL_LO  = 8;
  localparam int CF_NOISE   = 10;
  localparam int CF_TEST    = 11;
endpackage

// File: rtl/rng_bit_source.sv
module rng_bit_source #(
  parameter int          LFSR_W = 32,
  parameter logic [31:0] SEED   = 32'hACE1_2025,
  parameter logic [31:0] TAPS   = 32'h8020_0003
) (
  input  logic clk,
  input  logic rst_n,
  input  logic noise_en,
  input  logic test_mode,
  input  logic gather,
  input  logic raw_vld,
  input  logic raw_bit,
  output logic raw_rdy,
  output logic src_stb,
  output logic src_bit
);
  logic [LFSR_W-1:0] tst_q;
  logic              tst_step;

  assign raw_rdy  = noise_en & ~test_mode & gather;
  assign tst_step = noise_en & test_mode & gather;
  assign src_stb  = test_mode ? tst_step : (raw_vld & raw_rdy);
  assign src_bit  = test_mode ? tst_q[0] : raw_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tst_q <= SEED[LFSR_W-1:0];
    else if (tst_step)
      tst_q <= {1'b0, tst_q[LFSR_W-1:1]} ^ (tst_q[0] ? TAPS[LFSR_W-1:0] : '0);
  end
endmodule

// File: rtl/rng_lfsr_stage.sv
module rng_lfsr_stage #(
  parameter int          LFSR_W = 32,
  parameter logic [31:0] SEED   = 32'h0000_0001,
  parameter logic [31:0] TAPS   = 32'h8020_0003
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic in_stb,
  input  logic in_bit,
  output logic out_stb,
  output logic out_bit
);
  logic [LFSR_W-1:0] st_q;
  logic              fb;

  assign fb      = st_q[0] ^ in_bit;
  assign out_stb = in_stb;
  assign out_bit = enable ? fb : in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED[LFSR_W-1:0];
    else if (enable && in_stb)
      st_q <= {1'b0, st_q[LFSR_W-1:1]} ^ (fb ? TAPS[LFSR_W-1:0] : '0);
  end
endmodule

// File: rtl/rng_vn_whitener.sv
module rng_vn_whitener (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic in_stb,
  input  logic in_bit,
  output logic out_stb,
  output logic out_bit
);
  logic have_q, first_q;

  assign out_stb = enable ? (in_stb & have_q & (first_q != in_bit)) : in_stb;
  assign out_bit = enable ? first_q : in_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q  <= 1'b0;
      first_q <= 1'b0;
    end else if (enable && in_stb) begin
      have_q <= ~have_q;
      if (!have_q) first_q <= in_bit;
    end
  end
endmodule

// File: rtl/rng_word_acc.sv
module rng_word_acc #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_stb,
  input  logic              in_bit,
  input  logic              rd_en,
  output logic              gather,
  output logic              valid,
  output logic [WORD_W-1:0] word
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign gather = ~valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      valid <= 1'b0;
      word  <= '0;
    end else if (valid) begin
      if (rd_en) valid <= 1'b0;
    end else if (in_stb) begin
      sh_q <= {sh_q[WORD_W-2:0], in_bit};
      if (cnt_q == CNT_LAST) begin
        word  <= {sh_q[WORD_W-2:0], in_bit};
        valid <= 1'b1;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/rng_post_unit.sv
module rng_post_unit
  import rng_post_pkg::*;
#(
  parameter int          WORD_W    = 32,
  parameter int          LFSR_W    = 32,
  parameter logic [31:0] LFSR_TAPS = 32'h8020_0003,
  parameter logic [31:0] POST_SEED = 32'h0000_0001,
  parameter logic [31:0] TEST_SEED = 32'hACE1_2025
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       ctrl_word,
  input  logic              raw_vld,
  input  logic              raw_bit,
  output logic              raw_rdy,
  input  logic              rd_en,
  output logic [31:0]       stat_word,
  output logic [WORD_W-1:0] rd_data
);
  pp_sel_e sel;
  logic    noise_en, test_mode, gather, valid;
  logic    s_stb, s_bit, l_stb, l_bit, w_stb, w_bit;
  logic    unused_ctrl;

  assign sel         = pp_sel_e'(ctrl_word[CF_SEL_LO +: 2]);
  assign noise_en    = ctrl_word[CF_NOISE];
  assign test_mode   = ctrl_word[CF_TEST];
  assign unused_ctrl = ^{ctrl_word[7:0], ctrl_word[15:12]};

  rng_bit_source #(.LFSR_W(LFSR_W), .SEED(TEST_SEED), .TAPS(LFSR_TAPS)) u_src (
    .clk(clk), .rst_n(rst_n), .noise_en(noise_en), .test_mode(test_mode),
    .gather(gather), .raw_vld(raw_vld), .raw_bit(raw_bit), .raw_rdy(raw_rdy),
    .src_stb(s_stb), .src_bit(s_bit)
  );

  rng_lfsr_stage #(.LFSR_W(LFSR_W), .SEED(POST_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .enable(sel == PP_LFSR || sel == PP_BOTH),
    .in_stb(s_stb), .in_bit(s_bit), .out_stb(l_stb), .out_bit(l_bit)
  );

  rng_vn_whitener u_white (
    .clk(clk), .rst_n(rst_n), .enable(sel == PP_WHITE || sel == PP_BOTH),
    .in_stb(l_stb), .in_bit(l_bit), .out_stb(w_stb), .out_bit(w_bit)
  );

  rng_word_acc #(.WORD_W(WORD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .in_stb(w_stb), .in_bit(w_bit), .rd_en(rd_en),
    .gather(gather), .valid(valid), .word(rd_data)
  );

  assign stat_word = {31'd0, valid};
endmodule

// File: rtl/rng_post_unit_chk.sv
module rng_post_unit_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [15:0]       ctrl_word,
  input logic              raw_rdy,
  input logic              rd_en,
  input logic [31:0]       stat_word,
  input logic [WORD_W-1:0] rd_data
);
  AST_NOISE_OFF_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_word[10] && !stat_word[0]) |=> !stat_word[0]); // R2
  AST_NOISE_OFF_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_word[10] |-> !raw_rdy); // R2
  AST_TEST_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_word[11] |-> !raw_rdy); // R7
  AST_STAT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[31:1] == 31'd0); // R8
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_word[0] && rd_en) |=> !stat_word[0]); // R9
  AST_HELD_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[0] |=> $stable(rd_data)); // R10
  AST_HELD_NO_RDY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[0] |-> !raw_rdy); // R10
endmodule

bind rng_post_unit rng_post_unit_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .raw_rdy(raw_rdy),
  .rd_en(rd_en), .stat_word(stat_word), .rd_data(rd_data)
);

// File: tb/rng_post_unit_bench.sv
module rng_post_unit_bench;
  localparam logic [31:0] TAPS = 32'h8020_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl_word = 16'h0;
  logic        raw_vld = 1'b0, raw_bit = 1'b0, rd_en = 1'b0;
  logic        raw_rdy;
  logic [31:0] stat_word, rd_data;

  int total = 0, bad = 0;
  bit done = 0;

  logic [31:0] m_post, m_test;
  logic        m_have, m_first;
  int          m_cnt;
  logic [31:0] m_word;

  always #5 clk = ~clk;

  rng_post_unit u_rng_post_unit (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .raw_vld(raw_vld),
    .raw_bit(raw_bit), .raw_rdy(raw_rdy), .rd_en(rd_en),
    .stat_word(stat_word), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] step(input logic [31:0] s, input logic f);
    return (s >> 1) ^ (f ? TAPS : 32'h0);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; raw_vld = 0; rd_en = 0;
    m_post = 32'h1; m_test = 32'hACE1_2025; m_have = 0; m_first = 0;
    m_cnt = 0; m_word = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  // model of one accepted raw bit through the selected path (R3..R6)
  task automatic model_bit(input logic [1:0] sel, input logic b);
    logic x, emit, f;
    x = b; emit = 1;
    if (sel[0]) begin
      f = m_post[0] ^ x; m_post = step(m_post, f); x = f;
    end
    if (sel[1]) begin
      if (!m_have) begin m_have = 1; m_first = x; emit = 0; end
      else begin m_have = 0; emit = (m_first != x); x = m_first; end
    end
    if (emit) begin m_word = {m_word[30:0], x}; m_cnt++; end
  endtask

  function automatic logic gen(input int seed, input int i);
    logic [31:0] h;
    h = (i + seed) * 32'h9E37_79B1;
    return ^(h >> 9) ^ h[3];
  endfunction

  // feed raw bits until a word is held; the model predicts it
  task automatic fill_word(input logic [1:0] sel, input int seed, input string req);
    int i = 0;
    m_cnt = 0;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      if (stat_word[0]) break;
      raw_vld = 1; raw_bit = gen(seed, i);
      if (raw_rdy) model_bit(sel, raw_bit);
      i++;
      @(posedge clk);
    end
    raw_vld = 0;
    check(stat_word == 32'h1, req, stat_word, 32'h1);
    check(m_cnt == 32, req, m_cnt, 32);
    check(rd_data == m_word, req, rd_data, m_word);
  endtask

  task automatic read_word(input string req);
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check(stat_word == 32'h0, req, stat_word, 32'h0);
  endtask

  task automatic t_reset();
    do_reset();
    check(stat_word == 0, "R8 reset", stat_word, 0);
    check(raw_rdy == 0, "R2 reset rdy", raw_rdy, 0);
  endtask

  task automatic t_noise_off();
    do_reset();
    ctrl_word = 16'h03FF;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk); raw_vld = 1; raw_bit = k[0];
      if (raw_rdy) check(0, "R2 rdy while off", 1, 0);
    end
    raw_vld = 0;
    @(negedge clk);
    check(stat_word == 0, "R2 no valid", stat_word, 0);
    ctrl_word = 16'h0800;
    repeat (50) @(negedge clk);
    check(stat_word == 0, "R2 test without enable", stat_word, 0);
  endtask

  task automatic t_modes();
    logic [31:0] held;
    do_reset();
    ctrl_word = 16'hF4FF;                 // R1: junk outside 11:8, sel 0
    fill_word(2'd0, 3, "R1 R3 sel0 junk bits");
    // R10: bits offered while held are not taken
    held = rd_data;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk); raw_vld = 1; raw_bit = ~k[0];
      check(raw_rdy == 0, "R10 R11 rdy low while held", raw_rdy, 0);
    end
    raw_vld = 0;
    check(rd_data == held, "R10 word held", rd_data, held);
    read_word("R9 read clears");
    read_word("R9 read empty no effect");
    ctrl_word = 16'h0500;
    fill_word(2'd1, 11, "R4 lfsr");
    read_word("R9");
    ctrl_word = 16'h0600;
    fill_word(2'd2, 21, "R5 whitener");
    read_word("R9");
    fill_word(2'd2, 77, "R5 R10 refill");
    read_word("R9");
    ctrl_word = 16'h0700;
    fill_word(2'd3, 41, "R6 lfsr+whitener");
    read_word("R9");
  endtask

  task automatic t_test_mode();
    logic [31:0] exp, first;
    logic [31:0] t;
    t = 32'hACE1_2025; exp = 0;
    for (int k = 0; k < 32; k++) begin
      exp = {exp[30:0], t[0]}; t = step(t, t[0]);
    end
    for (int run = 0; run < 2; run++) begin
      do_reset();
      ctrl_word = 16'h0C00;
      for (int k = 0; k < 80; k++) begin
        @(negedge clk);
        raw_vld = 1; raw_bit = 1;
        if (raw_rdy) check(0, "R7 rdy in test", 1, 0);
        if (stat_word[0]) break;
      end
      raw_vld = 0;
      check(stat_word == 1, "R7 valid", stat_word, 1);
      check(rd_data == exp, "R7 word", rd_data, exp);
      if (run == 0) first = rd_data;
      else check(rd_data == first, "R7 repeatable", rd_data, first);
    end
    ctrl_word = 16'h0;
  endtask

  initial begin
    t_reset();
    t_noise_off();
    t_modes();
    t_test_mode();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule